// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface

This block is the processor-facing side of a tone signalling transceiver. A host reaches four functions over a nibble-wide data bus using one register-select line and single-cycle read and write strobes. With the select line low, it loads the transmit code or fetches the last received code. With the select line high, it writes control or reads status. Control writes go to one of two control registers. A one-shot pointer picks the register: setting the top bit of the first register sends exactly one following control write to the second register. After that write, control writes return to the first register.

The tone generator and detector sit outside this block and are seen only through simple strobes: a received-pair-valid pulse with its code, a transmitter-ready pulse, and a squared call-progress signal. The block drives an active-low shared pin. In tone-pair mode this pin is an interrupt request. In call-progress mode it carries the live squared waveform. The control bits are exported to the surrounding tone logic.

Top module: `tone_host_regs`

## Requirements
- R1: A write with `rsel`=0 loads `wdata` into `tx_code` and clears the transmit-empty flag. A read with `rsel`=0 returns the stored received code on `rdata` in the same cycle.
- R2: The first control register drives `tone_en` from bit 0, `cp_mode` from bit 1 and `irq_en` from bit 2. Its bit 3 arms the pointer to the second register.
- R3: The second control register drives `burst_en` from bit 0, `test_en` from bit 1, `single_tone` from bit 2 and `col_row` from bit 3.
- R4: A control write with bit 3 set sends the next control write to the second register. The write after that returns to the first register.
- R5: In tone-pair mode with `irq_en`=1, a `rx_valid` pulse stores `rx_code`, sets receive-full and the interrupt flag, and drives `irq_cp_n` low from the next cycle.
- R6: A `tx_ready` pulse sets transmit-empty. It raises the interrupt only when `burst_en`=1, `irq_en`=1 and tone-pair mode is selected.
- R7: A read with `rsel`=1 returns {0, receive-full, transmit-empty, interrupt} on bits 3..0 and clears the interrupt flag, so the pin returns high the next cycle. An interrupt event in the same cycle as the read keeps the flag set.
- R8: In call-progress mode, `irq_cp_n` follows `cp_sq` combinationally when `irq_en`=1 and stays high when `irq_en`=0.
- R9: In call-progress mode, `rx_valid` is ignored: the stored code, receive-full and the interrupt flag are left unchanged.
- R10: With `tone_en`=0, a transmit write raises no `tx_load`, and `tx_ready` is ignored.
- R11: With `tone_en`=1, a transmit write gives a one-cycle `tx_load` pulse in the cycle after the write.
- R12: After reset, both control registers are zero, the pointer selects the first register, all flags are clear and `irq_cp_n` is high.
- R13: Reading the received code clears receive-full. A `rx_valid` in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsel | input | 1 | Register select: 0 data, 1 control/status |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| wdata | input | DW | Write data nibble |
| rdata | output | DW | Read data, valid while `rd_en` is high, zero otherwise |
| rx_valid | input | 1 | Detector: tone pair accepted after guard time |
| rx_code | input | DW | Detector: received code |
| tx_ready | input | 1 | Generator: ready for the next code |
| cp_sq | input | 1 | Squared call-progress signal |
| tx_code | output | DW | Code to transmit |
| tx_load | output | 1 | One-cycle load pulse to the generator |
| tone_en | output | 1 | Tone output enable |
| cp_mode | output | 1 | 1 call-progress mode, 0 tone-pair mode |
| irq_en | output | 1 | Interrupt enable |
| burst_en | output | 1 | Burst mode |
| test_en | output | 1 | Test mode |
| single_tone | output | 1 | Single-tone select |
| col_row | output | 1 | Column/row select for single tones |
| irq_cp_n | output | 1 | Active-low interrupt or call-progress waveform |

## Verification
The hardest situation to reach is a status or receive read that lands in the same cycle as a new detector event. In that case the clearing action and the setting action collide, and the flag must survive. The stimulus drives the read strobe and `rx_valid` on the same falling edge. It then reads status again to confirm the pending flag and the pin level. Reaching the second control register also requires an arming write first. The sweep therefore walks each of the sixteen values through the arm, write-B, write-A order and checks that the second register kept its value.

// File: rtl/tone_host_regs.sv
module tone_host_regs #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rsel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_code,
  input  logic          tx_ready,
  input  logic          cp_sq,
  output logic [DW-1:0] tx_code,
  output logic          tx_load,
  output logic          tone_en,
  output logic          cp_mode,
  output logic          irq_en,
  output logic          burst_en,
  output logic          test_en,
  output logic          single_tone,
  output logic          col_row,
  output logic          irq_cp_n
);

  logic [3:0]    cra, crb;
  logic          ptr_b, irq_flag, rx_full, tx_empty;
  logic [DW-1:0] rx_q;

  wire wr_tx  = wr_en & ~rsel;
  wire wr_ctl = wr_en & rsel;
  wire rd_rx  = rd_en & ~rsel;
  wire rd_st  = rd_en & rsel;

  assign {irq_en, cp_mode, tone_en}                = cra[2:0];
  assign {col_row, single_tone, test_en, burst_en} = crb;

  wire rx_ev   = rx_valid & ~cp_mode;
  wire tx_ev   = tx_ready & tone_en;
  wire irq_set = irq_en & ~cp_mode & (rx_ev | (tx_ev & burst_en));

  wire [DW-1:0] status = {{(DW-3){1'b0}}, rx_full, tx_empty, irq_flag};

  assign rdata    = !rd_en ? '0 : (rsel ? status : rx_q);
  assign irq_cp_n = cp_mode ? (irq_en ? cp_sq : 1'b1) : ~irq_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cra      <= '0;
      crb      <= '0;
      ptr_b    <= 1'b0;
      irq_flag <= 1'b0;
      rx_full  <= 1'b0;
      tx_empty <= 1'b0;
      rx_q     <= '0;
      tx_code  <= '0;
      tx_load  <= 1'b0;
    end else begin
      if (wr_ctl) begin
        if (ptr_b) begin
          crb   <= wdata[3:0];
          ptr_b <= 1'b0;
        end else begin
          cra   <= wdata[3:0];
          ptr_b <= wdata[3];
        end
      end
      if (wr_tx) tx_code <= wdata;
      tx_load  <= wr_tx & tone_en;
      if (rx_ev) rx_q <= rx_code;
      rx_full  <= rx_ev | (rx_full & ~rd_rx);
      tx_empty <= ~wr_tx & (tx_ev | tx_empty);
      irq_flag <= irq_set | (irq_flag & ~rd_st);
    end
  end

  p_ptr_revert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && ptr_b) |=> !ptr_b);

  p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(rx_valid || tx_ready));

  p_stat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && !rx_valid && !tx_ready) |=> !irq_flag);

  p_cp_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_mode && rx_valid && !rd_rx && !rd_st) |=> ($stable(rx_q) && $stable(rx_full) && $stable(irq_flag)));

  p_tone_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tone_en && tx_ready && !wr_tx) |=> $stable(tx_empty));

endmodule

// File: tb/sim_tone_host_regs.sv
`timescale 1ns/1ps
module sim_tone_host_regs;
  logic clk = 0, rst_n = 0;
  logic rsel = 0, wr_en = 0, rd_en = 0, rx_valid = 0, tx_ready = 0, cp_sq = 0;
  logic [3:0] wdata = 0, rx_code = 0;
  logic [3:0] rdata, tx_code;
  logic tx_load, tone_en, cp_mode, irq_en, burst_en, test_en, single_tone, col_row, irq_cp_n;
  int total = 0, bad = 0;
  logic [3:0] s;

  always #2.5 clk = ~clk;

  tone_host_regs #(.DW(4)) u0 (.*);

  task automatic chk(input string r, input logic [7:0] a, input logic [7:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic wr(input logic rs, input logic [3:0] d);
    @(negedge clk); rsel = rs; wr_en = 1; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic rs, output logic [3:0] d);
    @(negedge clk); rsel = rs; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rxp(input logic [3:0] c);
    @(negedge clk); rx_valid = 1; rx_code = c;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic txp();
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 ctrl", {tone_en, cp_mode, irq_en, burst_en, test_en, single_tone, col_row}, 0);
    chk("R12 pin", irq_cp_n, 1);
    rd(1, s); chk("R12 status", s, 0);

    // R2/R3/R4 sweep through arm, write B, write A
    for (int v = 0; v < 16; v++) begin
      wr(1, 4'h8);
      chk("R2 armed low bits", {irq_en, cp_mode, tone_en}, 0);
      wr(1, v[3:0]);
      chk("R3 ctrl B", {col_row, single_tone, test_en, burst_en}, v[3:0]);
      wr(1, {1'b0, v[2:0]});
      chk("R2 ctrl A", {irq_en, cp_mode, tone_en}, v[2:0]);
      chk("R4 B kept", {col_row, single_tone, test_en, burst_en}, v[3:0]);
    end
    wr(1, 4'h8); wr(1, 4'h5); wr(1, 4'h3);
    chk("R4 back to A", {irq_en, cp_mode, tone_en}, 3'b011);
    chk("R4 B holds", {col_row, single_tone, test_en, burst_en}, 4'h5);

    // non-burst, tone on, irq on
    wr(1, 4'h8); wr(1, 4'h0); wr(1, 4'h5);
    for (int c = 0; c < 16; c++) begin
      rxp(c[3:0]);
      chk("R5 pin low", irq_cp_n, 0);
      rd(1, s); chk("R7 status", s, 4'b0101);
      chk("R7 pin high", irq_cp_n, 1);
      rd(0, s); chk("R1 rx data", s, c[3:0]);
      rd(1, s); chk("R13 full cleared", s, 0);
    end
    txp();
    chk("R6 no irq non-burst", irq_cp_n, 1);
    rd(1, s); chk("R6 tx empty", s, 4'b0010);
    wr(0, 4'h9);
    chk("R11 load pulse", tx_load, 1);
    chk("R1 tx code", tx_code, 4'h9);
    @(negedge clk);
    chk("R11 load one cycle", tx_load, 0);
    rd(1, s); chk("R1 empty cleared", s, 0);

    // burst
    wr(1, 4'h8); wr(1, 4'h1); wr(1, 4'h5);
    txp();
    chk("R6 burst irq", irq_cp_n, 0);
    rd(1, s); chk("R6 status", s, 4'b0011);
    chk("R7 pin high", irq_cp_n, 1);

    // R7 collision: status read with rx_valid
    @(negedge clk); rsel = 1; rd_en = 1; rx_valid = 1; rx_code = 4'hA;
    @(negedge clk); rd_en = 0; rx_valid = 0;
    chk("R7 event wins", irq_cp_n, 0);
    rd(1, s); chk("R7 flag kept", s, 4'b0111);
    rd(0, s); chk("R1 rx A", s, 4'hA);

    // R13 collision: rx read with rx_valid
    @(negedge clk); rsel = 0; rd_en = 1; rx_valid = 1; rx_code = 4'hB;
    @(negedge clk); rd_en = 0; rx_valid = 0;
    rd(1, s); chk("R13 full kept", s, 4'b0111);
    rd(0, s); chk("R13 rx B", s, 4'hB);
    rd(1, s); chk("R13 cleared", s, 4'b0010);

    // R10 tone off
    wr(1, 4'h4);
    wr(0, 4'h3);
    chk("R10 no load", tx_load, 0);
    chk("R1 tx code 3", tx_code, 4'h3);
    txp();
    chk("R10 no irq", irq_cp_n, 1);
    rd(1, s); chk("R10 ready ignored", s, 0);

    // R8/R9 call progress
    wr(1, 4'h6);
    @(negedge clk); cp_sq = 1; #1 chk("R8 follow 1", irq_cp_n, 1);
    @(negedge clk); cp_sq = 0; #1 chk("R8 follow 0", irq_cp_n, 0);
    rxp(4'h7);
    rd(1, s); chk("R9 no flags", s, 0);
    rd(0, s); chk("R9 data kept", s, 4'hB);
    wr(1, 4'h2);
    @(negedge clk); cp_sq = 0; #1 chk("R8 irq off high", irq_cp_n, 1);

    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule